// File: doc/BRIEF.md
# Power-Change System-Management Interrupt Controller

This block raises a system-management interrupt (SMI) whenever a power-sequence change is launched toward a socket's power switch. A sequence is launched after software writes a socket power setting. Each socket owns a pending flag. Software clears the flag by writing a 1 to it. Two further control bits are shared by all sockets: one enables SMI recording and one selects the delivery path.

When the route bit is 0, a pending SMI is delivered on that socket's card-status-change (CSC) interrupt line. A per-socket mode input selects the form of that interrupt: either a level that follows the pending flag, or a single-clock pulse when the flag first rises. When the route bit is 1, the pending flags of all sockets are merged into one request for the IRQ2 slot of the serial interrupt stream. Software reads the three control bits back through the same configuration word, and the pending bit in that word belongs to the socket that is addressed.

Top module: `smi_pwr_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every pending flag, the enable bit and the route bit are 0, and every interrupt output is 0.
- R2: A write to configuration address 0x80 loads enable from data bit 24 and route from data bit 26. A write to any other address changes nothing. The readback word carries route at bit 26, the pending flag of the selected socket at bit 25, enable at bit 24, and zeros in every other bit.
- R3: A power-sequence start pulse on a socket sets that socket's pending flag at the next clock edge, but only while enable is 1.
- R4: Writing 1 to bit 25 at address 0x80 clears the pending flag of the addressed socket only. Writing 0 to bit 25 leaves the flag unchanged, and the flag otherwise holds.
- R5: When a start pulse and a clear of the same socket occur in the same cycle with enable at 1, the pending flag ends set.
- R6: Clearing enable blocks new start pulses from being recorded, but leaves flags that are already pending unchanged.
- R7: With route 0, enable 1 and that socket's mode input at 0 (level), the socket's CSC interrupt equals its pending flag.
- R8: With route 0, enable 1 and the mode input at 1 (edge), the CSC interrupt is high for exactly the first clock cycle in which the pending flag reads 1, and low after that.
- R9: The IRQ2 request is the OR of all pending flags, gated by enable = 1 and route = 1. While route is 1, no CSC interrupt is driven.
- R10: Enable and route are shared by all sockets: a write addressed to any socket updates them for every socket.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Configuration write strobe |
| reg_wr_fn | input | FN_W | Socket addressed by the write |
| reg_addr | input | ADDR_W | Configuration write address |
| reg_wdata | input | 32 | Configuration write data |
| reg_rd_fn | input | FN_W | Socket whose pending flag appears in the readback |
| reg_rdata | output | 32 | Configuration readback word |
| pwr_seq_go | input | NUM_SOCK | Per-socket pulse marking that a power sequence was launched |
| csc_edge_sel | input | NUM_SOCK | Per-socket CSC mode: 1 selects edge, 0 selects level |
| csc_smi_irq | output | NUM_SOCK | Per-socket SMI delivered as a CSC interrupt |
| irq2_smi_req | output | 1 | SMI request for the IRQ2 serial slot |

## Verification
A power-sequence start and a write-one-to-clear can reach the same socket in the same clock cycle. The bench provokes this by driving both in one cycle on a socket that is already pending, and expects the flag to stay set with no second edge pulse. It also places a start pulse on one socket next to a clear of the other socket. A sweep over enable, route, mode and socket computes the expected readback word and the expected interrupt outputs from these bits, one cycle and two cycles after each start pulse.

// File: rtl/smi_pkg.sv
// Package: shared constants for the power-change SMI controller.
// Assumes a 32-bit configuration word whose SMI fields sit at fixed bits.
package smi_pkg;
    localparam int CFG_W      = 32;
    localparam int ROUTE_BIT  = 26;   // 1: IRQ2 serial slot, 0: CSC line
    localparam int STAT_BIT   = 25;   // per-socket pending, write-one-to-clear
    localparam int ENA_BIT    = 24;   // shared SMI enable

    typedef enum logic {
        PATH_CSC  = 1'b0,
        PATH_IRQ2 = 1'b1
    } smi_path_e;
endpackage

// File: rtl/smi_ctrl_shared.sv
// Module: holds the enable and route bits shared by every socket.
// Assumes ctrl_wr is already decoded to the configuration address.
module smi_ctrl_shared
    import smi_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ctrl_wr,
    input  logic      ena_in,
    input  logic      route_in,
    output logic      ena_q,
    output smi_path_e path_q
);
    // Load the shared bits on a decoded configuration write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ena_q  <= 1'b0;
            path_q <= PATH_CSC;
        end else if (ctrl_wr) begin
            ena_q  <= ena_in;
            path_q <= smi_path_e'(route_in);
        end
    end

    // R2 / R10: shared bits move only on a decoded write.
    a_r2_shared_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> ($stable(ena_q) && $stable(path_q)));
endmodule

// File: rtl/smi_pend_cell.sv
// Module: one socket's pending flag plus its rising-edge pulse.
// Assumes evt is a single-cycle pulse and clr is an already-decoded W1C.
module smi_pend_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic enable,
    input  logic clr,
    output logic pend_q,
    output logic rise_q
);
    logic set_now;
    assign set_now = evt && enable;

    // Pending flag: a set wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            rise_q <= 1'b0;
        end else begin
            pend_q <= (pend_q && !clr) || set_now;
            rise_q <= set_now && !pend_q;
        end
    end

    // R3 / R5: an enabled event always leaves the flag set.
    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && enable) |=> pend_q);
    // R4: without a clear the flag holds.
    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !clr) |=> pend_q);
    // R6: no enabled event means no new pending.
    a_r6_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_q && !(evt && enable)) |=> !pend_q);
    // R8: the edge pulse lasts one clock and coincides with pending.
    a_r8_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        rise_q |=> !rise_q);
    a_r8_with_pend: assert property (@(posedge clk) disable iff (!rst_n)
        rise_q |-> pend_q);
endmodule

// File: rtl/smi_csc_out.sv
// Module: forms one socket's CSC-delivered SMI in level or edge form.
// Assumes rise is a one-clock pulse aligned with the first pending cycle.
module smi_csc_out (
    input  logic pend,
    input  logic rise,
    input  logic edge_sel,
    input  logic deliver,
    output logic irq
);
    // Pick the edge pulse or the level, then gate by delivery path.
    always_comb begin
        irq = deliver && (edge_sel ? rise : pend);
    end
endmodule

// File: rtl/smi_pwr_irq_ctrl.sv
// Module: top of the power-change SMI controller.
// Decodes configuration writes, keeps per-socket pending flags and routes
// them to CSC lines or to the IRQ2 serial-slot request.
// Assumes one write per cycle and start pulses one clock wide.
module smi_pwr_irq_ctrl
    import smi_pkg::*;
#(
    parameter int                NUM_SOCK  = 2,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h80,
    localparam int               FN_W      = (NUM_SOCK > 1) ? $clog2(NUM_SOCK) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [FN_W-1:0]     reg_wr_fn,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [CFG_W-1:0]    reg_wdata,
    input  logic [FN_W-1:0]     reg_rd_fn,
    output logic [CFG_W-1:0]    reg_rdata,
    input  logic [NUM_SOCK-1:0] pwr_seq_go,
    input  logic [NUM_SOCK-1:0] csc_edge_sel,
    output logic [NUM_SOCK-1:0] csc_smi_irq,
    output logic                irq2_smi_req
);
    logic                ctrl_hit;
    logic                ena_q;
    smi_path_e           path_q;
    logic [NUM_SOCK-1:0] pend;
    logic [NUM_SOCK-1:0] rise;
    logic                csc_ok;

    assign ctrl_hit = reg_wr && (reg_addr == CTRL_ADDR);
    assign csc_ok   = ena_q && (path_q == PATH_CSC);

    smi_ctrl_shared u_shared (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (ctrl_hit),
        .ena_in   (reg_wdata[ENA_BIT]),
        .route_in (reg_wdata[ROUTE_BIT]),
        .ena_q    (ena_q),
        .path_q   (path_q)
    );

    for (genvar s = 0; s < NUM_SOCK; s++) begin : g_sock
        logic clr_s;
        // Clear only the addressed socket on a written 1.
        assign clr_s = ctrl_hit && reg_wdata[STAT_BIT] && (reg_wr_fn == FN_W'(s));

        smi_pend_cell u_pend (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt    (pwr_seq_go[s]),
            .enable (ena_q),
            .clr    (clr_s),
            .pend_q (pend[s]),
            .rise_q (rise[s])
        );

        smi_csc_out u_csc (
            .pend     (pend[s]),
            .rise     (rise[s]),
            .edge_sel (csc_edge_sel[s]),
            .deliver  (csc_ok),
            .irq      (csc_smi_irq[s])
        );
    end

    // Merge all pending flags into the serial-slot request.
    always_comb begin
        irq2_smi_req = ena_q && (path_q == PATH_IRQ2) && (|pend);
    end

    // Build the readback word for the selected socket.
    always_comb begin
        reg_rdata            = '0;
        reg_rdata[ROUTE_BIT] = path_q;
        reg_rdata[STAT_BIT]  = pend[reg_rd_fn];
        reg_rdata[ENA_BIT]   = ena_q;
    end

    // R9: serial-slot request only when enabled and routed there.
    a_r9_irq2_gate: assert property (@(posedge clk) disable iff (!rst_n)
        irq2_smi_req |-> (ena_q && path_q == PATH_IRQ2));
    // R9 / R7: no CSC delivery while routed to IRQ2 or disabled.
    a_r7_csc_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (|csc_smi_irq) |-> (ena_q && path_q == PATH_CSC));
endmodule

// File: tb/tb_smi_pwr_irq_ctrl.sv
`timescale 1ns/100ps
module tb_smi_pwr_irq_ctrl;
    localparam int N = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          reg_wr;
    logic [0:0]    reg_wr_fn;
    logic [7:0]    reg_addr;
    logic [31:0]   reg_wdata;
    logic [0:0]    reg_rd_fn;
    logic [31:0]   reg_rdata;
    logic [N-1:0]  pwr_seq_go;
    logic [N-1:0]  csc_edge_sel;
    logic [N-1:0]  csc_smi_irq;
    logic          irq2_smi_req;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    smi_pwr_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wr_fn(reg_wr_fn),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rd_fn(reg_rd_fn),
        .reg_rdata(reg_rdata), .pwr_seq_go(pwr_seq_go),
        .csc_edge_sel(csc_edge_sel), .csc_smi_irq(csc_smi_irq),
        .irq2_smi_req(irq2_smi_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word(input logic rt, input logic pd, input logic en);
        return {5'b0, rt, pd, en, 24'b0};
    endfunction

    // Drive one write for a cycle, starting and ending at a falling edge.
    task automatic wr(input logic [7:0] a, input logic fn, input logic en,
                      input logic rt, input logic clr);
        reg_wr = 1'b1; reg_addr = a; reg_wr_fn = fn;
        reg_wdata = 32'h00FF_FFFF | word(rt, clr, en);
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic go(input int s);
        pwr_seq_go[s] = 1'b1;
        @(negedge clk);
        pwr_seq_go = '0;
    endtask

    initial begin
        rst_n = 1'b0; reg_wr = 0; reg_wr_fn = 0; reg_addr = 0; reg_wdata = 0;
        reg_rd_fn = 0; pwr_seq_go = 0; csc_edge_sel = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 rdata fn0", reg_rdata, 32'h0);
        reg_rd_fn = 1;
        #0.1 check("R1 rdata fn1", reg_rdata, 32'h0);
        check("R1 outputs", {29'b0, csc_smi_irq, irq2_smi_req}, 32'h0);

        // Sweep: enable, route, mode, socket.
        for (int e = 0; e < 2; e++)
          for (int r = 0; r < 2; r++)
            for (int m = 0; m < 2; m++)
              for (int s = 0; s < N; s++) begin
                  logic ee, rr, mm;
                  logic [N-1:0] exp1, exp2, one;
                  ee = e[0]; rr = r[0]; mm = m[0];
                  one = N'(1) << s;
                  csc_edge_sel = {N{mm}};
                  wr(8'h80, 1'b0, ee, rr, 1'b1);
                  wr(8'h80, 1'b1, ee, rr, 1'b1);
                  reg_rd_fn = 1'(s);
                  #0.1 check("R4 cleared before event", reg_rdata, word(rr, 1'b0, ee));
                  go(s);
                  check("R2 R3 readback after start", reg_rdata, word(rr, ee, ee));
                  reg_rd_fn = 1'(1 - s);
                  #0.1 check("R3 other socket untouched", reg_rdata, word(rr, 1'b0, ee));
                  exp1 = (ee && !rr) ? one : '0;
                  check("R7 R8 csc first pending cycle", 32'(csc_smi_irq), 32'(exp1));
                  check("R9 irq2 request", 32'(irq2_smi_req), 32'(ee && rr));
                  @(negedge clk);
                  exp2 = (ee && !rr && !mm) ? one : '0;
                  check("R7 R8 csc second cycle", 32'(csc_smi_irq), 32'(exp2));
                  reg_rd_fn = 1'(s);
                  #0.1 check("R4 flag holds", reg_rdata, word(rr, ee, ee));
              end

        // R10: enable/route written via socket 1 seen in socket 0 readback.
        csc_edge_sel = '0;
        wr(8'h80, 1'b1, 1'b1, 1'b0, 1'b1);
        wr(8'h80, 1'b0, 1'b1, 1'b0, 1'b1);
        reg_rd_fn = 0;
        #0.1 check("R10 shared via fn1", reg_rdata, word(1'b0, 1'b0, 1'b1));
        // R2: write elsewhere ignored.
        wr(8'h84, 1'b0, 1'b0, 1'b1, 1'b0);
        check("R2 other address ignored", reg_rdata, word(1'b0, 1'b0, 1'b1));

        // R5: start and clear in the same cycle, socket 0 already pending.
        csc_edge_sel = 2'b11;
        go(0);
        check("R8 edge pulse", 32'(csc_smi_irq), 32'h1);
        @(negedge clk);
        pwr_seq_go = 2'b01;
        wr(8'h80, 1'b0, 1'b1, 1'b0, 1'b1);
        pwr_seq_go = '0;
        check("R5 set wins over clear", reg_rdata, word(1'b0, 1'b1, 1'b1));
        check("R5 no second edge pulse", 32'(csc_smi_irq), 32'h0);
        // R5: start on socket 1 next to a clear of socket 0.
        pwr_seq_go = 2'b10;
        wr(8'h80, 1'b0, 1'b1, 1'b0, 1'b1);
        pwr_seq_go = '0;
        check("R4 socket0 cleared", reg_rdata, word(1'b0, 1'b0, 1'b1));
        reg_rd_fn = 1;
        #0.1 check("R5 socket1 set", reg_rdata, word(1'b0, 1'b1, 1'b1));
        // R4: writing 0 to status leaves it.
        wr(8'h80, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R4 write zero no effect", reg_rdata, word(1'b0, 1'b1, 1'b1));

        // R6: disable keeps status, blocks new events.
        csc_edge_sel = 2'b00;
        wr(8'h80, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R6 status kept", reg_rdata, word(1'b0, 1'b1, 1'b0));
        check("R6 csc gated off", 32'(csc_smi_irq), 32'h0);
        go(0);
        reg_rd_fn = 0;
        #0.1 check("R6 new event blocked", reg_rdata, word(1'b0, 1'b0, 1'b0));
        // R9: re-enable routed to IRQ2, socket 1 still pending.
        wr(8'h80, 1'b0, 1'b1, 1'b1, 1'b0);
        check("R9 irq2 from socket1", 32'(irq2_smi_req), 32'h1);
        check("R9 csc silent on irq2 route", 32'(csc_smi_irq), 32'h0);
        // R1: reset again clears everything.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        reg_rd_fn = 1;
        #0.1 check("R1 reset clears", reg_rdata, 32'h0);
        check("R1 irq2 cleared", 32'(irq2_smi_req), 32'h0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule